// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps wall time as a 47-bit count that advances once per cycle of its own slow clock, which runs at 32.768 kHz. The upper 32 bits form the whole-seconds word. The lower 15 bits form the sub-second fraction, so the seconds word steps once every 32768 cycles. Software reads and writes the block through a small word-addressed bus. The read data is combinational from the address. A write takes effect at the clock edge where `bus_we` is high.

A seconds alarm compare sets a sticky alarm flag, and that flag drives the interrupt output through an enable bit. Counting halts in four cases:
- the control enable is clear;
- the stop input is high;
- the non-valid flag is set;
- the count has overflowed.

After a non-valid or overflow condition, clearing the flag alone does not restart the count. Counting resumes only after software also writes a new seconds value. The counter comes out of reset in the non-valid state, so it does not run until software has set the time.

Top module: `sec_alarm_timer`

## Requirements
- R1: Word map: 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status, 6 interrupt enable. After reset the words read as follows:
  - seconds and fraction read 0;
  - alarm seconds reads all ones;
  - control and interrupt enable read 0;
  - status reads 0x2, with non-valid set;
  - `alarm_irq` is low.
- R2: While running, the 47-bit count advances by one on every clock. The fraction (word 1, 15 bits) carries into the seconds word (word 0).
- R3: While the non-valid flag (status bit 1) is set, the count does not advance. Once the flag is cleared, the count still stays stopped until the seconds word is written.
- R4: A write to word 0 loads the seconds word and keeps the fraction. Counting starts on the next clock if every other run condition holds.
- R5: Clearing control bit 3 holds the count. Setting it again resumes counting from the held value without a reload.
- R6: While `stop_i` is high, the count is held, and status bit 0 reflects `stop_i`. Counting resumes when `stop_i` falls.
- R7: The alarm flag (status bit 4) is set on the clock where the count enters the alarm seconds value. A single match sets the flag once. `alarm_irq` is high exactly while the flag and interrupt enable bit 4 are both set.
- R8: Writing 1 to status bit 4, 2 or 1 clears that flag, and writing 0 leaves it unchanged. If a set event and a clear arrive in the same cycle, the set wins.
- R9: An alarm seconds value of all ones never sets the alarm flag, even when the count enters that second.
- R10: When the count steps past its all-ones value, it becomes zero, the overflow flag (status bit 2) is set, and counting halts. Counting stays halted after the flag is cleared until the seconds word is written.
- R11: The alarm fraction word (word 3) always reads zero, even after a write to it.
- R12: A high `invalid_i` sets the non-valid flag and halts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| invalid_i | input | 1 | Non-valid condition from the power monitor |
| stop_i | input | 1 | Failure stop from the tamper monitor |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The bench starts the counter a few cycles below a seconds boundary. This catches a carry or alarm compare that is off by one cycle, which would show up as a fraction or flag that is wrong by exactly one step.

It loads the count at the very top of the range and checks three behaviours there:
- the wrap to zero, with the overflow flag set;
- the freeze after the wrap;
- the refusal to restart until seconds are rewritten. A design that restarts as soon as the flag clears keeps counting past zero.

It also runs the count into the all-ones second with the never-fire alarm value, and sends a write-zero to the status word. A design that compares without the never-fire guard, or clears flags on any status write, raises a flag there.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_SEC   = 3'd0,
    RA_FRAC  = 3'd1,
    RA_ASEC  = 3'd2,
    RA_AFRAC = 3'd3,
    RA_CTRL  = 3'd4,
    RA_STAT  = 3'd5,
    RA_IEN   = 3'd6
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 3;
  localparam int IEN_ALM_BIT  = 4;
  localparam int ST_ALM_BIT   = 4;
  localparam int ST_OVF_BIT   = 2;
  localparam int ST_NV_BIT    = 1;
  localparam int ST_STOP_BIT  = 0;
endpackage

// File: rtl/sat_count_core.sv
module sat_count_core #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              halt,
  input  logic              kill,
  input  logic              sec_wr,
  input  logic              frac_wr,
  input  logic [SEC_W-1:0]  sec_wdata,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic [SEC_W-1:0]  alarm_sec,
  output logic [SEC_W-1:0]  sec_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic              running,
  output logic              wrap_evt,
  output logic              alarm_evt
);
  localparam int CNT_W = SEC_W + FRAC_W;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic [SEC_W-1:0] next_second(input logic [SEC_W-1:0] s);
    return s + SEC_W'(1);
  endfunction

  function automatic logic hits_alarm(input logic [SEC_W-1:0] s,
                                      input logic [SEC_W-1:0] a);
    return (next_second(s) == a) && !(&a);
  endfunction

  logic             loaded_q;
  logic             tick_sec;
  logic [CNT_W-1:0] cnt_next;

  assign running   = enable && loaded_q && !halt;
  assign tick_sec  = running && (&frac_q);
  assign wrap_evt  = tick_sec && (&sec_q);
  assign alarm_evt = tick_sec && hits_alarm(sec_q, alarm_sec);
  assign cnt_next  = step_count({sec_q, frac_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q    <= '0;
      frac_q   <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (sec_wr || frac_wr) begin
        if (sec_wr)  sec_q  <= sec_wdata;
        if (frac_wr) frac_q <= frac_wdata;
      end else if (running) begin
        {sec_q, frac_q} <= cnt_next;
      end
      if (sec_wr)
        loaded_q <= 1'b1;
      else if (kill || wrap_evt)
        loaded_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sat_flags.sv
module sat_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm_evt,
  input  logic wrap_evt,
  input  logic invalid_i,
  input  logic clr_alm,
  input  logic clr_ovf,
  input  logic clr_nv,
  output logic alm_f,
  output logic ovf_f,
  output logic nv_f
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_f <= 1'b0;
      ovf_f <= 1'b0;
      nv_f  <= 1'b1;
    end else begin
      if (alarm_evt)    alm_f <= 1'b1;
      else if (clr_alm) alm_f <= 1'b0;
      if (wrap_evt)     ovf_f <= 1'b1;
      else if (clr_ovf) ovf_f <= 1'b0;
      if (invalid_i)    nv_f  <= 1'b1;
      else if (clr_nv)  nv_f  <= 1'b0;
    end
  end
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sat_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              invalid_i,
  input  logic              stop_i,
  output logic              alarm_irq
);
  localparam int CNT_W = SEC_W + FRAC_W;

  logic [SEC_W-1:0]  sec_q;
  logic [FRAC_W-1:0] frac_q;
  logic [SEC_W-1:0]  alarm_sec_q;
  logic              run_en_q;
  logic              aie_q;
  logic              alm_f, ovf_f, nv_f;
  logic              running, wrap_evt, alarm_evt;
  logic              sec_wr, frac_wr, stat_wr, cnt_wr;
  logic [CNT_W-1:0]  count;

  assign sec_wr  = bus_we && (bus_addr == RA_SEC);
  assign frac_wr = bus_we && (bus_addr == RA_FRAC);
  assign stat_wr = bus_we && (bus_addr == RA_STAT);
  assign cnt_wr  = sec_wr || frac_wr;
  assign count   = {sec_q, frac_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_sec_q <= '1;
      run_en_q    <= 1'b0;
      aie_q       <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        RA_ASEC: alarm_sec_q <= bus_wdata[SEC_W-1:0];
        RA_CTRL: run_en_q    <= bus_wdata[CTRL_RUN_BIT];
        RA_IEN:  aie_q       <= bus_wdata[IEN_ALM_BIT];
        default: ;
      endcase
    end
  end

  sat_count_core #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (run_en_q),
    .halt       (ovf_f || nv_f || stop_i),
    .kill       (ovf_f || nv_f),
    .sec_wr     (sec_wr),
    .frac_wr    (frac_wr),
    .sec_wdata  (bus_wdata[SEC_W-1:0]),
    .frac_wdata (bus_wdata[FRAC_W-1:0]),
    .alarm_sec  (alarm_sec_q),
    .sec_q      (sec_q),
    .frac_q     (frac_q),
    .running    (running),
    .wrap_evt   (wrap_evt),
    .alarm_evt  (alarm_evt)
  );

  sat_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .alarm_evt (alarm_evt),
    .wrap_evt  (wrap_evt),
    .invalid_i (invalid_i),
    .clr_alm   (stat_wr && bus_wdata[ST_ALM_BIT]),
    .clr_ovf   (stat_wr && bus_wdata[ST_OVF_BIT]),
    .clr_nv    (stat_wr && bus_wdata[ST_NV_BIT]),
    .alm_f     (alm_f),
    .ovf_f     (ovf_f),
    .nv_f      (nv_f)
  );

  assign alarm_irq = alm_f && aie_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_SEC:  bus_rdata[SEC_W-1:0]  = sec_q;
      RA_FRAC: bus_rdata[FRAC_W-1:0] = frac_q;
      RA_ASEC: bus_rdata[SEC_W-1:0]  = alarm_sec_q;
      RA_CTRL: bus_rdata[CTRL_RUN_BIT] = run_en_q;
      RA_STAT: begin
        bus_rdata[ST_ALM_BIT]  = alm_f;
        bus_rdata[ST_OVF_BIT]  = ovf_f;
        bus_rdata[ST_NV_BIT]   = nv_f;
        bus_rdata[ST_STOP_BIT] = stop_i;
      end
      RA_IEN:  bus_rdata[IEN_ALM_BIT] = aie_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sec_alarm_timer_chk.sv
module sec_alarm_timer_chk #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      running,
  input logic                      wrap_evt,
  input logic                      alarm_evt,
  input logic                      cnt_wr,
  input logic [SEC_W+FRAC_W-1:0]   count,
  input logic                      ovf_f,
  input logic                      alm_f,
  input logic [SEC_W-1:0]          alarm_sec,
  input logic                      alarm_irq
);
  localparam int CNT_W = SEC_W + FRAC_W;

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cnt_wr && !wrap_evt) |=> (count == $past(count) + CNT_W'(1)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cnt_wr) |=> $stable(count));

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (ovf_f && count == '0));

  // R10
  ovf_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_f |-> !running);

  // R7
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> alm_f);

  // R7
  alarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_f) |-> $past(alarm_evt));

  // R9
  never_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |-> !(&alarm_sec));

  // R7
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alm_f);
endmodule

bind sec_alarm_timer sec_alarm_timer_chk #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .running   (running),
  .wrap_evt  (wrap_evt),
  .alarm_evt (alarm_evt),
  .cnt_wr    (cnt_wr),
  .count     (count),
  .ovf_f     (ovf_f),
  .alm_f     (alm_f),
  .alarm_sec (alarm_sec_q),
  .alarm_irq (alarm_irq)
);

// File: tb/sec_alarm_timer_test.sv
module sec_alarm_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        invalid_i = 1'b0;
  logic        stop_i = 1'b0;
  logic        alarm_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sec_alarm_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .invalid_i(invalid_i),
    .stop_i(stop_i), .alarm_irq(alarm_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [46:0] exp_count(input logic [31:0] s, input logic [14:0] f, input int n);
    return {s, f} + 47'(n);
  endfunction

  function automatic logic exp_alarm(input bit plus_one, input int n, input int r);
    return plus_one && (n >= r);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before end of run");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd0, v); check("R1 seconds", v, 0);
    rd(3'd1, v); check("R1 fraction", v, 0);
    rd(3'd2, v); check("R1 alarm seconds", v, 32'hFFFF_FFFF);
    rd(3'd4, v); check("R1 control", v, 0);
    rd(3'd5, v); check("R1 status", v, 32'h2);
    rd(3'd6, v); check("R1 irq enable", v, 0);
    check("R1 irq", alarm_irq, 0);

    // R3 non-valid blocks counting
    wr(3'd4, 32'h8);
    wr(3'd0, 32'd100);
    wait_n(10);
    rd(3'd1, v); check("R3 held while non-valid", v, 0);
    wr(3'd5, 32'h2);
    rd(3'd5, v); check("R3 non-valid cleared", v, 0);
    wait_n(10);
    rd(3'd1, v); check("R3 no restart before seconds write", v, 0);
    // R4 seconds write starts counting
    wr(3'd0, 32'd100);
    wait_n(5);
    rd(3'd0, v); check("R4 seconds loaded", v, 100);
    rd(3'd1, v); check("R4 R2 counting", v, 5);

    // R5 enable gate
    wr(3'd4, 32'h0);
    rd(3'd1, v); check("R5 count at disable", v, 6);
    wait_n(10);
    rd(3'd1, v); check("R5 held while disabled", v, 6);
    wr(3'd4, 32'h8);
    wait_n(4);
    rd(3'd1, v); check("R5 resumed", v, 10);

    // R6 stop input
    stop_i = 1'b1;
    wait_n(5);
    rd(3'd1, v); check("R6 held while stopped", v, 10);
    rd(3'd5, v); check("R6 stop status bit", v, 32'h1);
    stop_i = 1'b0;
    wait_n(3);
    rd(3'd1, v); check("R6 resumed", v, 13);

    // R11 alarm fraction
    wr(3'd3, 32'h1234);
    rd(3'd3, v); check("R11 alarm fraction zero", v, 0);

    // R7 alarm at boundary
    wr(3'd4, 32'h0);
    wr(3'd1, 32'h7FFD);
    wr(3'd0, 32'd200);
    wr(3'd2, 32'd201);
    wr(3'd6, 32'h10);
    wr(3'd4, 32'h8);
    wait_n(2);
    rd(3'd5, v); check("R7 no flag before boundary", v, 0);
    check("R7 no irq before boundary", alarm_irq, 0);
    wait_n(1);
    rd(3'd5, v); check("R7 flag at boundary", v, 32'h10);
    rd(3'd0, v); check("R7 seconds at boundary", v, 201);
    rd(3'd1, v); check("R2 fraction carry", v, 0);
    check("R7 irq raised", alarm_irq, 1);
    wr(3'd6, 32'h0);
    check("R7 irq masked", alarm_irq, 0);
    wr(3'd6, 32'h10);
    // R8 write zero keeps flag
    wr(3'd5, 32'h0);
    rd(3'd5, v); check("R8 write zero no effect", v, 32'h10);
    wr(3'd5, 32'h10);
    rd(3'd5, v); check("R8 alarm flag cleared", v, 0);
    wait_n(20);
    rd(3'd5, v); check("R7 single set per match", v, 0);
    check("R7 irq low after clear", alarm_irq, 0);

    // R9 all-ones alarm never fires
    wr(3'd4, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd1, 32'h7FF0);
    wr(3'd0, 32'hFFFF_FFFE);
    wr(3'd4, 32'h8);
    wait_n(20);
    rd(3'd0, v); check("R9 entered all-ones second", v, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R9 fraction", v, 4);
    rd(3'd5, v); check("R9 no alarm flag", v, 0);

    // R10 overflow
    wr(3'd4, 32'h0);
    wr(3'd1, 32'h7FF0);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd4, 32'h8);
    wait_n(20);
    rd(3'd0, v); rd(3'd1, v2);
    check("R10 wrapped to zero", {v, v2}, 0);
    rd(3'd5, v); check("R10 overflow flag", v, 32'h4);
    wr(3'd5, 32'h4);
    wait_n(5);
    rd(3'd1, v); check("R10 stays halted after clear", v, 0);
    rd(3'd5, v); check("R10 flag cleared", v, 0);
    wr(3'd0, 32'd7);
    wait_n(3);
    rd(3'd0, v); rd(3'd1, v2);
    check("R10 restart after seconds write", {v, v2}, {32'd7, 32'd3});

    // R12 invalid input
    invalid_i = 1'b1;
    @(negedge clk);
    invalid_i = 1'b0;
    rd(3'd1, v);
    wait_n(5);
    rd(3'd1, v2); check("R12 halted by invalid", v2, v);
    rd(3'd5, v); check("R12 non-valid flag", v, 32'h2);

    // random trials: R2 R4 R7
    for (int t = 0; t < 40; t++) begin
      logic [31:0] s;
      int r;
      int n;
      bit plus_one;
      bit aie;
      logic [46:0] e;
      logic ef;
      s = $urandom & 32'h7FFF_FFFF;
      r = 1 + ($urandom % 40);
      n = 1 + ($urandom % 60);
      plus_one = $urandom % 2;
      aie = $urandom % 2;
      wr(3'd4, 32'h0);
      wr(3'd5, 32'h16);
      wr(3'd2, plus_one ? s + 1 : s + 2);
      wr(3'd6, aie ? 32'h10 : 32'h0);
      wr(3'd1, 32'(32768 - r));
      wr(3'd0, s);
      wr(3'd4, 32'h8);
      wait_n(n);
      e = exp_count(s, 15'(32768 - r), n);
      ef = exp_alarm(plus_one, n, r);
      rd(3'd0, v); check("R2 random seconds", v, e[46:15]);
      rd(3'd1, v); check("R2 random fraction", v, e[14:0]);
      rd(3'd5, v); check("R7 random flag", v, ef ? 32'h10 : 32'h0);
      check("R7 random irq", alarm_irq, ef && aie);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule